// File: doc/BRIEF.md
# Indirect 8080 host port

This block is the slave side of an 8080-style host bus that reaches the chip through indirect addressing. The host has a 16-bit data bus (split here into an input, an output and an output enable), a chip select, read and write strobes, and a data/command select. The host does not put addresses on the bus. It writes two command words that carry a start address, a memory-or-register flag and a byte-or-word mode. From then on every data cycle uses an internal address counter, and that counter moves on by the access size after each transfer.

Each data cycle turns into a one-cycle internal request. The request carries a memory/register select, a 19-bit byte address, the access size and the write data. Reads use a prefetch. The first data read after setup, or after any write, returns zero as a dummy value and fetches the word at the counter. Each later read returns the word fetched by the read before it and starts the next fetch. A command read returns a status word. The host pins are sampled on the core clock, and a bus cycle needs at least 7 core clocks.

Top module: `host8080_port`

## Requirements
- R1: After reset, dbOe is 0, dbOut is 0x0000, no request is issued, and a status read returns 0x0000.
- R2: A command write (dcN=0, wrN=0 at the falling edge of csN) taken as the upper word sets these fields: bit 15 is the memory flag (1 = memory, 0 = register) and bits 10:0 become address bits 18:8. The command write that follows supplies address bits 7:0 from bits 15:8. Only then is the start address loaded.
- R3: Bits 7:0 of the lower command word pick the size. Only the value 0x01 selects word access; 0x00 and every other value select byte access. The size appears on reqWord.
- R4: A data cycle (dcN=1) is ignored while the two-word setup is incomplete. This covers the time after reset and the time after an upper word with no lower word. Such a cycle issues no request, and a read returns 0x0000.
- R5: Each data write (dcN=1, wrN=0 at a csN fall) issues exactly one request of one cycle with reqWrite=1 at the counter address. In word mode reqWdata equals the bus word. In byte mode reqWdata is {8'h00, bus[7:0]}.
- R6: After each data read or write, the counter advances by 1 in byte mode and by 2 in word mode.
- R7: For memory accesses, the counter returns to 0 after address 0x3FFFF in byte mode and after 0x3FFFE in word mode. For register accesses, it only wraps at the 19-bit limit, so 0x3FFFE steps to 0x40000 in word mode.
- R8: The first data read after setup drives 0x0000 and issues a read request at the start address. Each later read drives the data returned for the previous read request and issues a read request at the next address.
- R9: In byte mode a read drives the returned byte on bits 7:0 and 0x00 on bits 15:8.
- R10: A data write cancels the prefetch, so the next data read is again a dummy that drives 0x0000.
- R11: A command read (dcN=0, rdN=0, wrN=1) returns {memory flag, setup-complete flag, 3'b000, counter bits 18:8}. It issues no request and leaves the counter unchanged.
- R12: dbOe is high only while the sampled csN and rdN are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Bus chip select, active low; its falling edge latches a cycle |
| rdN | input | 1 | Bus read strobe, active low |
| wrN | input | 1 | Bus write strobe, active low |
| dcN | input | 1 | Data/command select: 0 command, 1 data |
| dbIn | input | 16 | Data bus from the host |
| dbOut | output | 16 | Data bus toward the host |
| dbOe | output | 1 | Output enable for dbOut |
| reqValid | output | 1 | One-cycle internal request strobe |
| reqWrite | output | 1 | Request is a write |
| reqMem | output | 1 | Request targets memory (1) or registers (0) |
| reqAddr | output | 19 | Byte address of the request |
| reqWord | output | 1 | Word (1) or byte (0) access |
| reqWdata | output | 16 | Write data of the request |
| rspValid | input | 1 | Read data for the last read request is valid |
| rspData | input | 16 | Read data; in byte mode the byte sits in bits 7:0 |

## Verification
The bench builds the port with its default parameters: a 19-bit address and an 18-bit memory ceiling. Start addresses are set just below the memory ceiling in both sizes, and at the top of the register space. Both wrap rules, and the register side that does not follow the memory ceiling, are therefore reached within a few bus cycles instead of a full sweep. A stand-in back end answers each read request two clocks later with data derived from the address. This lets the prefetch ordering be checked word by word.

// File: rtl/host8080_pkg.sv
package host8080_pkg;
  localparam int HOST_DW = 16;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic doWrite;
    logic doRead;
    logic outZero;
    logic outBuf;
    logic outStatus;
  } hostStrobe_t;
endpackage

// File: rtl/host8080_ctrl.sv
module host8080_ctrl
  import host8080_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csN,
  input  logic               rdN,
  input  logic               wrN,
  input  logic               dcN,
  input  logic [HOST_DW-1:0] dbIn,
  output logic [HOST_DW-1:0] dbSamp,
  output logic               dbOe,
  output logic               addrReady,
  output hostStrobe_t        strobe
);
  typedef enum logic [1:0] {ST_NOADDR, ST_HALF, ST_READY} setupState_t;

  setupState_t state;
  logic sCs, sRd, sWr, sDc, prevCs, dummyPend;
  logic csFall;

  // pins are sampled once on the core clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sCs    <= 1'b1;
      sRd    <= 1'b1;
      sWr    <= 1'b1;
      sDc    <= 1'b1;
      prevCs <= 1'b1;
      dbSamp <= '0;
    end else begin
      sCs    <= csN;
      sRd    <= rdN;
      sWr    <= wrN;
      sDc    <= dcN;
      prevCs <= sCs;
      dbSamp <= dbIn;
    end
  end

  assign csFall    = prevCs & ~sCs;
  assign dbOe      = ~sCs & ~sRd;
  assign addrReady = (state == ST_READY);

  always_comb begin
    strobe = '0;
    if (csFall) begin
      if (!sDc) begin
        if (!sWr) begin
          if (state == ST_HALF) strobe.loadLo = 1'b1;
          else                  strobe.loadHi = 1'b1;
        end else if (!sRd) begin
          strobe.outStatus = 1'b1;
        end
      end else begin
        if (!sWr) begin
          if (state == ST_READY) strobe.doWrite = 1'b1;
        end else if (!sRd) begin
          if (state == ST_READY) begin
            strobe.doRead = 1'b1;
            if (dummyPend) strobe.outZero = 1'b1;
            else           strobe.outBuf  = 1'b1;
          end else begin
            strobe.outZero = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_NOADDR;
      dummyPend <= 1'b1;
    end else begin
      if (strobe.loadHi)      state <= ST_HALF;
      else if (strobe.loadLo) state <= ST_READY;

      if (strobe.loadLo || strobe.doWrite) dummyPend <= 1'b1;
      else if (strobe.doRead)              dummyPend <= 1'b0;
    end
  end
endmodule

// File: rtl/host8080_dp.sv
module host8080_dp
  import host8080_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int MEM_AW = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  hostStrobe_t        strobe,
  input  logic [HOST_DW-1:0] dbSamp,
  input  logic               addrReady,
  input  logic               rspValid,
  input  logic [HOST_DW-1:0] rspData,
  output logic [HOST_DW-1:0] dbOut,
  output logic               reqValid,
  output logic               reqWrite,
  output logic               reqMem,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic               reqWord,
  output logic [HOST_DW-1:0] reqWdata
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int PAD_W = HOST_DW - 2 - HI_W;
  localparam logic [ADDR_W-1:0] BYTE_TOP = ADDR_W'((64'd1 << MEM_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] WORD_TOP = ADDR_W'((64'd1 << MEM_AW) - 64'd2);

  logic              memFlag, memSel, wordMode;
  logic [HI_W-1:0]   hiAddr;
  logic [ADDR_W-1:0] cnt, cntNext, ceilVal;
  logic [HOST_DW-1:0] rdBuf, wdataFmt, statusWord;

  assign ceilVal = wordMode ? WORD_TOP : BYTE_TOP;

  always_comb begin
    if (memSel && (cnt >= ceilVal)) cntNext = '0;
    else cntNext = cnt + (wordMode ? ADDR_W'(2) : ADDR_W'(1));
  end

  assign wdataFmt   = wordMode ? dbSamp : {8'h00, dbSamp[7:0]};
  assign statusWord = {memSel, addrReady, {PAD_W{1'b0}}, cnt[ADDR_W-1:8]};

  // address and mode registers, counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memFlag  <= 1'b0;
      memSel   <= 1'b0;
      wordMode <= 1'b0;
      hiAddr   <= '0;
      cnt      <= '0;
    end else if (strobe.loadHi) begin
      memFlag <= dbSamp[HOST_DW-1];
      hiAddr  <= dbSamp[HI_W-1:0];
    end else if (strobe.loadLo) begin
      cnt      <= {hiAddr, dbSamp[15:8]};
      wordMode <= (dbSamp[7:0] == 8'h01);
      memSel   <= memFlag;
    end else if (strobe.doWrite || strobe.doRead) begin
      cnt <= cntNext;
    end
  end

  // internal request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqValid <= 1'b0;
      reqWrite <= 1'b0;
      reqMem   <= 1'b0;
      reqAddr  <= '0;
      reqWord  <= 1'b0;
      reqWdata <= '0;
    end else begin
      reqValid <= strobe.doWrite | strobe.doRead;
      if (strobe.doWrite || strobe.doRead) begin
        reqWrite <= strobe.doWrite;
        reqMem   <= memSel;
        reqAddr  <= cnt;
        reqWord  <= wordMode;
        reqWdata <= strobe.doWrite ? wdataFmt : '0;
      end
    end
  end

  // prefetch buffer and bus output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdBuf <= '0;
      dbOut <= '0;
    end else begin
      if (rspValid) rdBuf <= rspData;
      if (strobe.outZero)        dbOut <= '0;
      else if (strobe.outBuf)    dbOut <= wordMode ? rdBuf : {8'h00, rdBuf[7:0]};
      else if (strobe.outStatus) dbOut <= statusWord;
    end
  end
endmodule

// File: rtl/host8080_port.sv
module host8080_port
  import host8080_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int MEM_AW = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csN,
  input  logic               rdN,
  input  logic               wrN,
  input  logic               dcN,
  input  logic [HOST_DW-1:0] dbIn,
  output logic [HOST_DW-1:0] dbOut,
  output logic               dbOe,
  output logic               reqValid,
  output logic               reqWrite,
  output logic               reqMem,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic               reqWord,
  output logic [HOST_DW-1:0] reqWdata,
  input  logic               rspValid,
  input  logic [HOST_DW-1:0] rspData
);
  hostStrobe_t        strobe;
  logic [HOST_DW-1:0] dbSamp;
  logic               addrReady;

  host8080_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rdN(rdN), .wrN(wrN), .dcN(dcN),
    .dbIn(dbIn), .dbSamp(dbSamp), .dbOe(dbOe), .addrReady(addrReady),
    .strobe(strobe)
  );

  host8080_dp #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .dbSamp(dbSamp),
    .addrReady(addrReady), .rspValid(rspValid), .rspData(rspData),
    .dbOut(dbOut), .reqValid(reqValid), .reqWrite(reqWrite), .reqMem(reqMem),
    .reqAddr(reqAddr), .reqWord(reqWord), .reqWdata(reqWdata)
  );
endmodule

// File: rtl/host8080_port_chk.sv
module host8080_port_chk #(
  parameter int ADDR_W = 19,
  parameter int MEM_AW = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csN,
  input logic              rdN,
  input logic              dbOe,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqMem,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWord,
  input logic [15:0]       reqWdata,
  input logic              addrReady,
  input logic              setupLoad
);
  localparam logic [ADDR_W-1:0] MEM_LAST = ADDR_W'((64'd1 << MEM_AW) - 64'd1);

  logic              havePrev, lastWord, lastMem;
  logic [ADDR_W-1:0] lastAddr, expAddr;
  logic              lastAtCeil;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      havePrev <= 1'b0;
      lastWord <= 1'b0;
      lastMem  <= 1'b0;
      lastAddr <= '0;
    end else if (reqValid) begin
      havePrev <= 1'b1;
      lastWord <= reqWord;
      lastMem  <= reqMem;
      lastAddr <= reqAddr;
    end else if (setupLoad) begin
      havePrev <= 1'b0;
    end
  end

  assign lastAtCeil = lastMem && (lastWord ? (lastAddr >= MEM_LAST - ADDR_W'(1))
                                           : (lastAddr == MEM_LAST));
  assign expAddr = lastAtCeil ? '0 : lastAddr + (lastWord ? ADDR_W'(2) : ADDR_W'(1));

  AST_ONE_PULSE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> !reqValid); // R5

  AST_NO_REQ_BEFORE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> $past(addrReady)); // R4

  AST_BYTE_WDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite && !reqWord) |-> (reqWdata[15:8] == 8'h00)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && havePrev && !lastAtCeil) |-> (reqAddr == expAddr)); // R6

  AST_MEM_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && havePrev && lastAtCeil) |-> (reqAddr == '0)); // R7

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dbOe |-> $past(!csN && !rdN)); // R12
endmodule

bind host8080_port host8080_port_chk #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .csN(csN), .rdN(rdN), .dbOe(dbOe),
  .reqValid(reqValid), .reqWrite(reqWrite), .reqMem(reqMem), .reqAddr(reqAddr),
  .reqWord(reqWord), .reqWdata(reqWdata), .addrReady(addrReady),
  .setupLoad(strobe.loadLo)
);

// File: tb/host8080_port_tb.sv
module host8080_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  typedef struct {
    logic          isWrite;
    logic          mem;
    logic [AW-1:0] addr;
    logic          word;
    logic [15:0]   wdata;
    string         tag;
  } expReq_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, dcN = 1'b1;
  logic [15:0] dbIn = '0;
  logic [15:0] dbOut;
  logic dbOe, reqValid, reqWrite, reqMem, reqWord;
  logic [AW-1:0] reqAddr;
  logic [15:0] reqWdata;
  logic rspValid = 1'b0;
  logic [15:0] rspData = '0;

  int checks = 0, errors = 0, reqSeen = 0;
  bit finished = 0;
  expReq_t expQ[$];
  logic [15:0] lastDb;
  logic lastOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  host8080_port dut_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rdN(rdN), .wrN(wrN), .dcN(dcN),
    .dbIn(dbIn), .dbOut(dbOut), .dbOe(dbOe), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqMem(reqMem), .reqAddr(reqAddr), .reqWord(reqWord),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData)
  );

  function automatic logic [15:0] rdf(logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  // stand-in back end: answers each read request two clocks later
  logic p1 = 1'b0;
  logic [AW-1:0] a1 = '0;
  always @(posedge clk) begin
    p1       <= reqValid & ~reqWrite;
    a1       <= reqAddr;
    rspValid <= p1;
    rspData  <= rdf(a1);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && reqValid && !finished) begin
      reqSeen++;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected request actual=%h expected=none", reqAddr);
      end else begin
        expReq_t e;
        e = expQ.pop_front();
        chk({e.tag, " reqWrite"}, 32'(reqWrite), 32'(e.isWrite));
        chk({e.tag, " reqMem"},   32'(reqMem),   32'(e.mem));
        chk({e.tag, " reqAddr"},  32'(reqAddr),  32'(e.addr));
        chk({e.tag, " reqWord"},  32'(reqWord),  32'(e.word));
        if (e.isWrite) chk({e.tag, " reqWdata"}, 32'(reqWdata), 32'(e.wdata));
      end
    end
  end

  task automatic pushReq(logic w, logic m, logic [AW-1:0] a, logic wd, logic [15:0] d, string tag);
    expReq_t e;
    e.isWrite = w; e.mem = m; e.addr = a; e.word = wd; e.wdata = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  // one bus cycle; dbOut/dbOe sampled while csN is still low
  task automatic bus(logic dc, logic isWr, logic [15:0] d);
    @(negedge clk);
    dcN = dc; rdN = isWr; wrN = ~isWr; dbIn = d;
    @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    lastDb = dbOut; lastOe = dbOe;
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmdWr(logic [15:0] d);
    bus(1'b0, 1'b1, d);
  endtask

  task automatic statusRd(logic [15:0] exp, string tag);
    bus(1'b0, 1'b0, 16'h0);
    chk(tag, 32'(lastDb), 32'(exp));
  endtask

  task automatic setup(logic m, logic [AW-1:0] a, logic [7:0] mode);
    cmdWr({m, 4'b0000, a[18:8]});
    cmdWr({a[7:0], mode});
  endtask

  task automatic dWr(logic [15:0] d);
    bus(1'b1, 1'b1, d);
  endtask

  task automatic dRd(logic [15:0] exp, string tag);
    bus(1'b1, 1'b0, 16'h0);
    chk(tag, 32'(lastDb), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dbOe", 32'(dbOe), 0);
    chk("R1 reqValid", 32'(reqValid), 0);
    chk("R1 dbOut", 32'(dbOut), 0);
    statusRd(16'h0000, "R1 status after reset");
    chk("R12 dbOe in read", 32'(lastOe), 1);

    // R4 data before setup ignored
    seen = reqSeen;
    dWr(16'h1111);
    chk("R12 dbOe in write", 32'(lastOe), 0);
    dRd(16'h0000, "R4 read before setup");
    cmdWr(16'h8012);
    dWr(16'h2222);
    dRd(16'h0000, "R4 read after upper word only");
    chk("R4 no request", 32'(reqSeen), 32'(seen));
    statusRd(16'h0000, "R4 status half setup");

    // R2 R3 R5 R6 R11 word writes
    cmdWr(16'h3401);
    statusRd(16'hC012, "R11 status after setup");
    pushReq(1, 1, 19'h01234, 1, 16'hBEEF, "R2 first word write");
    dWr(16'hBEEF);
    statusRd(16'hC012, "R11 status mid stream");
    pushReq(1, 1, 19'h01236, 1, 16'h1234, "R6 word step");
    dWr(16'h1234);
    pushReq(1, 1, 19'h01238, 1, 16'hA5A5, "R6 word step 2");
    dWr(16'hA5A5);

    // R8 prefetch reads
    setup(1, 19'h01234, 8'h01);
    pushReq(0, 1, 19'h01234, 1, 0, "R8 dummy fetch");
    dRd(16'h0000, "R8 dummy read");
    pushReq(0, 1, 19'h01236, 1, 0, "R8 fetch 2");
    dRd(rdf(19'h01234), "R8 read data N");
    pushReq(0, 1, 19'h01238, 1, 0, "R8 fetch 3");
    dRd(rdf(19'h01236), "R8 read data N+1");

    // R10 write cancels prefetch
    pushReq(1, 1, 19'h0123A, 1, 16'h5555, "R10 write");
    dWr(16'h5555);
    pushReq(0, 1, 19'h0123C, 1, 0, "R10 refetch");
    dRd(16'h0000, "R10 dummy after write");

    // R7 byte wrap in memory, R5 byte wdata, R9 byte read
    setup(1, 19'h3FFFE, 8'h00);
    pushReq(1, 1, 19'h3FFFE, 0, 16'h00CD, "R5 byte wdata");
    dWr(16'hABCD);
    pushReq(1, 1, 19'h3FFFF, 0, 16'h0034, "R6 byte step");
    dWr(16'h1234);
    pushReq(1, 1, 19'h00000, 0, 16'h0078, "R7 byte wrap");
    dWr(16'h5678);
    pushReq(0, 1, 19'h00001, 0, 0, "R9 dummy fetch");
    dRd(16'h0000, "R9 dummy");
    pushReq(0, 1, 19'h00002, 0, 0, "R9 fetch 2");
    dRd({8'h00, rdf(19'h00001)[7:0]}, "R9 byte read");

    // R7 word wrap in memory
    setup(1, 19'h3FFFC, 8'h01);
    pushReq(1, 1, 19'h3FFFC, 1, 16'h0101, "R7 word a");
    dWr(16'h0101);
    pushReq(1, 1, 19'h3FFFE, 1, 16'h0202, "R7 word b");
    dWr(16'h0202);
    pushReq(1, 1, 19'h00000, 1, 16'h0303, "R7 word wrap");
    dWr(16'h0303);

    // R7 register space ignores memory ceiling
    setup(0, 19'h3FFFE, 8'h01);
    statusRd(16'h43FF, "R11 status register space");
    pushReq(1, 0, 19'h3FFFE, 1, 16'h0404, "R7 reg word a");
    dWr(16'h0404);
    pushReq(1, 0, 19'h40000, 1, 16'h0505, "R7 reg past ceiling");
    dWr(16'h0505);
    setup(0, 19'h7FFFF, 8'h00);
    pushReq(1, 0, 19'h7FFFF, 0, 16'h0006, "R7 reg top");
    dWr(16'h0606);
    pushReq(1, 0, 19'h00000, 0, 16'h0007, "R7 reg natural wrap");
    dWr(16'h0707);

    // R3 other mode codes select byte
    setup(1, 19'h00010, 8'h02);
    pushReq(1, 1, 19'h00010, 0, 16'h0088, "R3 mode 02 byte");
    dWr(16'h7788);
    pushReq(1, 1, 19'h00011, 0, 16'h0099, "R3 mode 02 step");
    dWr(16'h6699);

    repeat (5) @(negedge clk);
    chk("R5 all expected requests seen", 32'(expQ.size()), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule